// File: doc/BRIEF.md
# Port Direction Register with Byte-Lane Writes

This block holds the direction setting for the 32 pins of one general-purpose I/O port. A memory-mapped bus writes and reads a single 32-bit register. Each write carries one strobe per byte lane, so software can change one byte, one half-word or the whole word without first reading the register back. Every stored bit picks input (0) or output (1) for the pin with the same index. The block turns those bits into registered per-pin output enables for the pad drivers.

Two pins of the port share a differential interface and must always point the same way. The block couples them: both pins drive only when both of their direction bits are 1. If either bit is 0, both pins stay inputs. Readback always returns the stored bits as written, not the coupled enables. Software can therefore see a half-configured pair.

Top module: `gpio_dir_reg`

## Requirements
- R1: After synchronous reset every direction bit is 0, `pin_oe` is all zeros and `rdata` is 0, so every pin starts as an input.
- R2: For a pin n outside the coupled pair, `pin_oe[n]` is 1 when stored bit n is 1 (output) and 0 when it is 0 (input).
- R3: When `wr_en` is 1, each byte lane k whose strobe `be[k]` is 1 loads bits 8k+7..8k from the same bit positions of `wdata`. Lanes whose strobe is 0 keep their value. This holds for any strobe pattern, including non-adjacent lanes.
- R4: A half-word write (`be` = 4'b0011 for bits 15..0, or 4'b1100 for bits 31..16) changes exactly those 16 bits. A word write (`be` = 4'b1111) changes all 32 bits.
- R5: A write with `wr_en` at 0, or with `wr_en` at 1 and `be` = 4'b0000, leaves every stored bit unchanged.
- R6: A write sampled at a rising clock edge is stored at that edge. A read issued in the very next cycle returns the new value.
- R7: `pin_oe` is registered. It reflects the stored bits one clock edge after they change, and holds its old value during the cycle in which the write lands.
- R8: Pins 29 and 30 are coupled. Both `pin_oe[29]` and `pin_oe[30]` are 1 only when stored bits 29 and 30 are both 1. Otherwise both are 0.
- R9: Readback returns the stored bits, so bit 29 or bit 30 can read as 1 while both coupled enables are 0.
- R10: `rdata` is loaded with the stored register at the rising edge where `rd_en` is 1, and it holds its value while `rd_en` is 0.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request for the direction register |
| rd_en | input | 1 | Read request; `rdata` updates at the next edge |
| be | input | 4 | Byte-lane write strobes, bit k covers bits 8k+7..8k |
| wdata | input | 32 | Write data, lane-aligned |
| rdata | output | 32 | Registered readback of the stored direction bits |
| pin_oe | output | 32 | Registered per-pin output enables, coupling applied |

## Verification
The bench builds the block with its default parameters: 32 pins, 8-bit lanes and the coupled pair at pins 29 and 30. With these values the coupled pair falls inside the top byte lane. A single-lane write can then set one half of the pair while the readback still shows it. With four strobes, the bench can try every size of access and also a non-adjacent strobe pattern. Each of these accesses is compared with an independent model of the register.

// File: rtl/gpio_dir_pkg.sv
package gpio_dir_pkg;

  localparam int unsigned DEF_NUM_PINS = 32;
  localparam int unsigned DEF_LANE_W   = 8;
  localparam int unsigned DEF_PAIR_LO  = 29;
  localparam int unsigned DEF_PAIR_HI  = 30;

  localparam logic DIR_INPUT  = 1'b0;
  localparam logic DIR_OUTPUT = 1'b1;

endpackage

// File: rtl/gpio_dir_store.sv
module gpio_dir_store #(
  parameter int unsigned NUM_PINS = gpio_dir_pkg::DEF_NUM_PINS,
  parameter int unsigned LANE_W   = gpio_dir_pkg::DEF_LANE_W,
  localparam int unsigned NUM_LANES = NUM_PINS / LANE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [NUM_LANES-1:0] be,
  input  logic [NUM_PINS-1:0]  wdata,
  output logic [NUM_PINS-1:0]  dir_q
);

  if (NUM_PINS % LANE_W != 0) begin : g_bad_geometry
    $error("gpio_dir_store: NUM_PINS must be a multiple of LANE_W");
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        lane_q <= {LANE_W{gpio_dir_pkg::DIR_INPUT}};
      end else if (wr_en && be[g]) begin
        lane_q <= wdata[g*LANE_W +: LANE_W];
      end
    end

    assign dir_q[g*LANE_W +: LANE_W] = lane_q;

    // R5
    lane_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && be[g]) |=> $stable(dir_q[g*LANE_W +: LANE_W]));

    // R3
    lane_load_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && be[g]) |=> dir_q[g*LANE_W +: LANE_W] == $past(wdata[g*LANE_W +: LANE_W]));
  end

endmodule

// File: rtl/gpio_dir_couple.sv
module gpio_dir_couple #(
  parameter int unsigned NUM_PINS = gpio_dir_pkg::DEF_NUM_PINS,
  parameter int unsigned PAIR_LO  = gpio_dir_pkg::DEF_PAIR_LO,
  parameter int unsigned PAIR_HI  = gpio_dir_pkg::DEF_PAIR_HI
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] dir_q,
  output logic [NUM_PINS-1:0] pin_oe
);

  if (PAIR_LO >= NUM_PINS || PAIR_HI >= NUM_PINS || PAIR_LO == PAIR_HI) begin : g_bad_pair
    $error("gpio_dir_couple: coupled pins must be distinct and inside the port");
  end

  logic                pair_drive;
  logic [NUM_PINS-1:0] oe_next;

  always_comb begin
    pair_drive       = dir_q[PAIR_LO] & dir_q[PAIR_HI];
    oe_next          = dir_q;
    oe_next[PAIR_LO] = pair_drive;
    oe_next[PAIR_HI] = pair_drive;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_oe <= '0;
    end else begin
      pin_oe <= oe_next;
    end
  end

  // R8
  pair_match_chk: assert property (@(posedge clk) disable iff (rst)
    pin_oe[PAIR_LO] == pin_oe[PAIR_HI]);

  // R8
  pair_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !(dir_q[PAIR_LO] && dir_q[PAIR_HI]) |=> !pin_oe[PAIR_LO]);

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    if (g != PAIR_LO && g != PAIR_HI) begin : g_plain
      // R2 R7
      oe_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> pin_oe[g] == $past(dir_q[g]));
    end
  end

endmodule

// File: rtl/gpio_dir_readback.sv
module gpio_dir_readback #(
  parameter int unsigned NUM_PINS = gpio_dir_pkg::DEF_NUM_PINS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_en,
  input  logic [NUM_PINS-1:0] dir_q,
  output logic [NUM_PINS-1:0] rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= dir_q;
    end
  end

  // R9 R10
  read_load_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rdata == $past(dir_q));

  // R10
  read_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

endmodule

// File: rtl/gpio_dir_reg.sv
module gpio_dir_reg #(
  parameter int unsigned NUM_PINS = gpio_dir_pkg::DEF_NUM_PINS,
  parameter int unsigned LANE_W   = gpio_dir_pkg::DEF_LANE_W,
  parameter int unsigned PAIR_LO  = gpio_dir_pkg::DEF_PAIR_LO,
  parameter int unsigned PAIR_HI  = gpio_dir_pkg::DEF_PAIR_HI,
  localparam int unsigned NUM_LANES = NUM_PINS / LANE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [NUM_LANES-1:0] be,
  input  logic [NUM_PINS-1:0]  wdata,
  output logic [NUM_PINS-1:0]  rdata,
  output logic [NUM_PINS-1:0]  pin_oe
);

  logic [NUM_PINS-1:0] dir_q;

  gpio_dir_store #(
    .NUM_PINS (NUM_PINS),
    .LANE_W   (LANE_W)
  ) u_store (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .be    (be),
    .wdata (wdata),
    .dir_q (dir_q)
  );

  gpio_dir_couple #(
    .NUM_PINS (NUM_PINS),
    .PAIR_LO  (PAIR_LO),
    .PAIR_HI  (PAIR_HI)
  ) u_couple (
    .clk    (clk),
    .rst    (rst),
    .dir_q  (dir_q),
    .pin_oe (pin_oe)
  );

  gpio_dir_readback #(
    .NUM_PINS (NUM_PINS)
  ) u_readback (
    .clk   (clk),
    .rst   (rst),
    .rd_en (rd_en),
    .dir_q (dir_q),
    .rdata (rdata)
  );

endmodule

// File: tb/gpio_dir_reg_tb.sv
`timescale 1ns/1ps
module gpio_dir_reg_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  be = 4'h0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pin_oe;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;
  logic        done = 1'b0;

  logic [31:0] model = '0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_pend = 1'b0;

  always #2.5 clk = ~clk;

  gpio_dir_reg u_dut (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .be     (be),
    .wdata  (wdata),
    .rdata  (rdata),
    .pin_oe (pin_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_oe(input logic [31:0] m);
    logic [31:0] e;
    e = m;
    e[29] = m[29] & m[30];
    e[30] = m[29] & m[30];
    return e;
  endfunction

  // driver: one write, returns at the falling edge after the storing edge
  task automatic do_write(input logic [3:0] strobes, input logic [31:0] d, input logic en);
    @(negedge clk);
    wr_en = en;
    be    = strobes;
    wdata = d;
    if (en) begin
      for (int k = 0; k < 4; k++) begin
        if (strobes[k]) model[k*8 +: 8] = d[k*8 +: 8];
      end
    end
    @(negedge clk);
    wr_en = 1'b0;
    be    = 4'h0;
    wdata = '0;
  endtask

  // driver: one read, pushes the expected readback into the scoreboard
  task automatic do_read(input string tag);
    @(negedge clk);
    rd_en = 1'b1;
    exp_q.push_back(model);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // monitor
  always @(posedge clk) rd_pend <= rd_en && !rst;

  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) begin
        chk("scoreboard underflow", rdata, 32'hx);
      end else begin
        chk(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic settle_oe(input string tag);
    @(negedge clk);
    chk(tag, pin_oe, exp_oe(model));
  endtask

  initial begin
    logic [31:0] old_oe;
    repeat (4) @(negedge clk);
    chk("R1 oe after reset", pin_oe, 32'h0);
    chk("R1 rdata after reset", rdata, 32'h0);
    rst = 1'b0;
    do_read("R1 read after reset");

    // word write and registered enables
    old_oe = pin_oe;
    do_write(4'b1111, 32'hA5A5_0F0F, 1'b1);
    chk("R7 oe holds during write cycle", pin_oe, old_oe);
    settle_oe("R2 R4 word write enables");
    do_read("R4 word write readback");

    // single lanes
    for (int k = 0; k < 4; k++) begin
      do_write(4'b0001 << k, 32'h3C3C_3C3C ^ (32'h11 << (8 * k)), 1'b1);
      do_read("R3 single lane readback");
    end
    settle_oe("R2 lane write enables");

    // half-words
    do_write(4'b0011, 32'hFFFF_1234, 1'b1);
    do_read("R4 low half readback");
    do_write(4'b1100, 32'h0081_FFFF, 1'b1);
    do_read("R4 high half readback");
    settle_oe("R2 half write enables");

    // non-adjacent lanes
    do_write(4'b0101, 32'hEEEE_EEEE, 1'b1);
    do_read("R3 split strobe readback");

    // ignored writes
    old_oe = pin_oe;
    do_write(4'b0000, 32'h0000_0000, 1'b1);
    do_write(4'b1111, 32'h0000_0000, 1'b0);
    do_read("R5 ignored writes readback");
    @(negedge clk);
    chk("R5 oe unchanged", pin_oe, old_oe);

    // back-to-back write then read
    do_write(4'b1111, 32'h0F00_00F0, 1'b1);
    do_read("R6 read right after write");

    // coupled pair
    do_write(4'b1000, 32'h2000_0000, 1'b1);
    settle_oe("R8 only bit 29 set");
    chk("R8 pin 29 input", {31'h0, pin_oe[29]}, 32'h0);
    do_read("R9 bit 29 reads as stored");
    do_write(4'b1000, 32'h4000_0000, 1'b1);
    settle_oe("R8 only bit 30 set");
    chk("R8 pin 30 input", {31'h0, pin_oe[30]}, 32'h0);
    do_read("R9 bit 30 reads as stored");
    do_write(4'b1000, 32'h6000_0000, 1'b1);
    settle_oe("R8 both set");
    chk("R8 pair drives", {30'h0, pin_oe[30:29]}, 32'h3);

    // rdata holds without rd_en
    do_read("R10 read before change");
    do_write(4'b1111, 32'h1357_9BDF, 1'b1);
    @(negedge clk);
    chk("R10 rdata holds without read", rdata, 32'h6000_0000 | 32'h0F00_00F0 & 32'h00FF_FFFF);
    do_read("R10 read after change");
    settle_oe("R2 final enables");

    // reset again mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    model = '0;
    chk("R1 oe after second reset", pin_oe, 32'h0);
    chk("R1 rdata after second reset", rdata, 32'h0);
    rst = 1'b0;
    do_read("R1 read after second reset");

    repeat (3) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 32'h0);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule